// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetcher

This block walks a circular list of transmit buffer descriptors kept in shared memory and hands each ready buffer to a data mover. Software programs a ring base address, fills one or more descriptors, sets their ready flags and then pulses a kick strobe. The block reads descriptors one after another through a simple request/acknowledge memory port. For each ready descriptor it offers the buffer pointer, the byte length and the end-of-frame and append-checksum flags to the data mover. When the mover reports completion, the block rewrites the descriptor's flag halfword with the ready flag cleared, which returns ownership to software.

Walking stops at a descriptor whose ready flag is clear. Before stopping, the block reads that same descriptor one extra time. A kick that arrives while the block is busy is held and replayed once the block goes idle. Dropping the controller enable puts the walker back at the ring base. The block never fills in descriptor contents on its own.

Top module: `txd_ring_fetcher`

## Requirements
- R1: While enabled and idle, a one-cycle kick strobe starts fetching at the current descriptor address, and only the strobe matters.
- R2: A descriptor is two 32-bit words. Word 0 holds ready (bit 31), wrap (bit 30), last-in-frame (bit 29), append-CRC (bit 28), other flag bits (27:16) and length (15:0). Word 1 holds the buffer pointer. Descriptors follow each other every 8 bytes.
- R3: Ready descriptors are handled in ring order. For each one, `dm_valid` offers the pointer, length, last and CRC flags, and the offer stays stable until `dm_ready`.
- R4: After `dm_done`, the block writes word 0 with byte enables 4'b1100. The ready bit is cleared and flag bits 30:16 are kept. The length and the pointer word are left unchanged.
- R5: After a descriptor whose wrap bit is set, the next descriptor is read at the ring base. The block never reads past that descriptor.
- R6: When word 0 shows ready = 0, the same word is read exactly once more. If it is still 0, the block goes idle and issues no memory request until the next kick.
- R7: If the second read shows ready = 1, the descriptor is processed normally.
- R8: A kick that arrives while fetching is in progress is remembered. It restarts fetching at the current descriptor after the block goes idle.
- R9: While `enable` is low, the descriptor address follows the ring base, the outputs are idle, kicks are ignored, and no descriptor is written.
- R10: The ring base register forces address bits 1:0 to zero.
- R11: A memory request keeps its address and direction stable until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Controller enable; low holds the walker at the ring base |
| base_wr | input | 1 | Write strobe for the ring base register |
| base_wdata | input | AW | Ring base address value |
| kick | input | 1 | Start strobe for fetching |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_be | output | 4 | Byte enables for writes |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access done (one-cycle pulse) |
| dm_valid | output | 1 | Buffer offer to the data mover |
| dm_ready | input | 1 | Data mover accepts the offer |
| dm_ptr | output | 32 | Buffer pointer |
| dm_len | output | 16 | Buffer length |
| dm_last | output | 1 | Buffer ends a frame |
| dm_crc | output | 1 | Mover should append the CRC |
| dm_done | input | 1 | Buffer transfer finished |

## Verification
Two events can land in the same cycle: a software kick and the end of the double poll, when the block has just decided a descriptor is still not ready. The bench provokes this by letting its memory model set the ready flag only after the second poll has returned the old value, while a kick is issued during the previous buffer's offer. It then judges the result by the number of buffer offers and memory accesses that follow. A lost kick would leave one offer instead of two, and a missed second poll would show up in the access count and in the rescue case where the flag is set between the two polls.

// File: rtl/txd_pkg.sv
package txd_pkg;
  // Flag positions inside the upper halfword of descriptor word 0
  localparam int FB_READY = 15;
  localparam int FB_WRAP  = 14;
  localparam int FB_LAST  = 13;
  localparam int FB_CRC   = 12;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LAUNCH,
    S_HDR,
    S_PTR,
    S_OFFER,
    S_XFER,
    S_WB
  } seq_t;
endpackage

// File: rtl/txd_cfg.sv
module txd_cfg #(
  parameter int AW    = 32,
  parameter int ALIGN = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          base_wr,
  input  logic [AW-1:0] base_wdata,
  input  logic          kick,
  input  logic          busy,
  input  logic          take,
  output logic [AW-1:0] base,
  output logic          start_req
);
  localparam logic [AW-1:0] LOW_MASK = AW'(ALIGN - 1);

  logic pend;

  always_ff @(posedge clk) begin
    if (rst) base <= '0;
    else if (base_wr) base <= base_wdata & ~LOW_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) pend <= 1'b0;
    else if (kick && busy) pend <= 1'b1;
    else if (take) pend <= 1'b0;
  end

  assign start_req = enable && (kick || pend);

  // R8: a kick taken while busy must still be asking for a start next cycle
  assert_kick_kept_R8: assert property (@(posedge clk) disable iff (rst)
    enable && kick && busy |=> (start_req || !enable));

  // R9: a kick with the controller disabled leaves nothing pending
  assert_kick_dropped_R9: assert property (@(posedge clk) disable iff (rst)
    !enable && kick |=> !start_req || kick);
endmodule

// File: rtl/txd_ptr.sv
module txd_ptr #(
  parameter int AW     = 32,
  parameter int STRIDE = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic [AW-1:0] base,
  input  logic          advance,
  input  logic          wrap,
  output logic [AW-1:0] cur
);
  always_ff @(posedge clk) begin
    if (rst || !enable) cur <= base;
    else if (advance) cur <= wrap ? base : cur + AW'(STRIDE);
  end

  // R9: disabled controller parks the walker at the ring base
  assert_park_base_R9: assert property (@(posedge clk) disable iff (rst)
    !enable |=> cur == $past(base));
endmodule

// File: rtl/txd_seq.sv
module txd_seq
  import txd_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int LEN_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            enable,
  input  logic            start_req,
  input  logic [AW-1:0]   cur,
  output logic            busy,
  output logic            take,
  output logic            advance,
  output logic            wrap,
  output logic            mem_req,
  output logic            mem_we,
  output logic [DW/8-1:0] mem_be,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_ack,
  output logic            dm_valid,
  input  logic            dm_ready,
  output logic [DW-1:0]   dm_ptr,
  output logic [LEN_W-1:0] dm_len,
  output logic            dm_last,
  output logic            dm_crc,
  input  logic            dm_done
);
  localparam int HW      = DW / 2;
  localparam int BE_W    = DW / 8;
  localparam int WORD_B  = DW / 8;
  localparam logic [BE_W-1:0] UPPER_BE = {{(BE_W/2){1'b1}}, {(BE_W/2){1'b0}}};
  localparam logic [HW-1:0]   RDY_MASK = HW'(1) << FB_READY;

  seq_t          state;
  logic          second;
  logic [HW-1:0] flags;

  assign busy    = (state != S_IDLE);
  assign take    = (state == S_IDLE) && start_req;
  assign advance = (state == S_WB) && mem_ack;
  assign wrap    = flags[FB_WRAP];

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      state     <= S_IDLE;
      second    <= 1'b0;
      flags     <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_be    <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      dm_valid  <= 1'b0;
      dm_ptr    <= '0;
      dm_len    <= '0;
      dm_last   <= 1'b0;
      dm_crc    <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start_req) begin
            second <= 1'b0;
            state  <= S_LAUNCH;
          end
        end
        S_LAUNCH: begin
          mem_req  <= 1'b1;
          mem_we   <= 1'b0;
          mem_be   <= '0;
          mem_addr <= cur;
          state    <= S_HDR;
        end
        S_HDR: begin
          if (mem_ack) begin
            if (mem_rdata[HW + FB_READY]) begin
              flags    <= mem_rdata[DW-1:HW];
              dm_len   <= mem_rdata[LEN_W-1:0];
              second   <= 1'b0;
              mem_addr <= cur + AW'(WORD_B);
              state    <= S_PTR;
            end else if (!second) begin
              second  <= 1'b1;
              mem_req <= 1'b0;
              state   <= S_LAUNCH;
            end else begin
              mem_req <= 1'b0;
              state   <= S_IDLE;
            end
          end
        end
        S_PTR: begin
          if (mem_ack) begin
            mem_req  <= 1'b0;
            dm_ptr   <= mem_rdata;
            dm_last  <= flags[FB_LAST];
            dm_crc   <= flags[FB_CRC];
            dm_valid <= 1'b1;
            state    <= S_OFFER;
          end
        end
        S_OFFER: begin
          if (dm_ready) begin
            dm_valid <= 1'b0;
            state    <= S_XFER;
          end
        end
        S_XFER: begin
          if (dm_done) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_be    <= UPPER_BE;
            mem_addr  <= cur;
            mem_wdata <= {flags & ~RDY_MASK, {HW{1'b0}}};
            state     <= S_WB;
          end
        end
        S_WB: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            mem_be  <= '0;
            state   <= S_LAUNCH;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R11: request, address and direction held until acknowledged
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
    enable && mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R4: write-back touches only the flag halfword and releases the descriptor
  assert_wb_release_R4: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> (mem_be == UPPER_BE) && !mem_wdata[DW-1]);

  // R3: offer held stable until accepted
  assert_offer_hold_R3: assert property (@(posedge clk) disable iff (rst)
    enable && dm_valid && !dm_ready |=> dm_valid && $stable(dm_ptr) && $stable(dm_len));

  // R10: every access uses a word-aligned address
  assert_word_addr_R10: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> mem_addr[1:0] == 2'b00);

  // R6: an idle walker without a start issues no request next cycle
  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    state == S_IDLE && !start_req && !mem_req |=> !mem_req);
endmodule

// File: rtl/txd_ring_fetcher.sv
module txd_ring_fetcher #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             base_wr,
  input  logic [AW-1:0]    base_wdata,
  input  logic             kick,
  output logic             mem_req,
  output logic             mem_we,
  output logic [DW/8-1:0]  mem_be,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             mem_ack,
  output logic             dm_valid,
  input  logic             dm_ready,
  output logic [DW-1:0]    dm_ptr,
  output logic [LEN_W-1:0] dm_len,
  output logic             dm_last,
  output logic             dm_crc,
  input  logic             dm_done
);
  localparam int WORD_B = DW / 8;
  localparam int STRIDE = 2 * WORD_B;

  logic [AW-1:0] base;
  logic [AW-1:0] cur;
  logic          start_req;
  logic          busy;
  logic          take;
  logic          advance;
  logic          wrap;

  txd_cfg #(.AW(AW), .ALIGN(WORD_B)) u_cfg (
    .clk(clk), .rst(rst), .enable(enable),
    .base_wr(base_wr), .base_wdata(base_wdata),
    .kick(kick), .busy(busy), .take(take),
    .base(base), .start_req(start_req)
  );

  txd_ptr #(.AW(AW), .STRIDE(STRIDE)) u_ptr (
    .clk(clk), .rst(rst), .enable(enable),
    .base(base), .advance(advance), .wrap(wrap), .cur(cur)
  );

  txd_seq #(.AW(AW), .DW(DW), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst(rst), .enable(enable),
    .start_req(start_req), .cur(cur),
    .busy(busy), .take(take), .advance(advance), .wrap(wrap),
    .mem_req(mem_req), .mem_we(mem_we), .mem_be(mem_be),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .dm_valid(dm_valid), .dm_ready(dm_ready),
    .dm_ptr(dm_ptr), .dm_len(dm_len),
    .dm_last(dm_last), .dm_crc(dm_crc), .dm_done(dm_done)
  );
endmodule

// File: tb/test_txd_ring_fetcher.sv
module test_txd_ring_fetcher;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic        base_wr = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        kick = 1'b0;
  logic        mem_req, mem_we;
  logic [3:0]  mem_be;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic        dm_valid;
  logic        dm_ready = 1'b0;
  logic [31:0] dm_ptr;
  logic [15:0] dm_len;
  logic        dm_last, dm_crc;
  logic        dm_done = 1'b0;

  always #4 clk = ~clk;

  txd_ring_fetcher i_txd_ring_fetcher (
    .clk(clk), .rst(rst), .enable(enable),
    .base_wr(base_wr), .base_wdata(base_wdata), .kick(kick),
    .mem_req(mem_req), .mem_we(mem_we), .mem_be(mem_be),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .dm_valid(dm_valid), .dm_ready(dm_ready),
    .dm_ptr(dm_ptr), .dm_len(dm_len),
    .dm_last(dm_last), .dm_crc(dm_crc), .dm_done(dm_done)
  );

  localparam int BASEW = 16;  // word index of byte address 0x40

  logic [31:0] mem [0:63];
  int rd_hist [0:63];
  int acc_count, hold_err, first_seen;
  logic [31:0] first_addr;
  int lat, dly_r, dly_d;
  int arm_idx, arm_left;
  int wait_cnt;
  int checks, fails;
  bit done_flag;

  logic [31:0] lg_ptr [0:15];
  logic [15:0] lg_len [0:15];
  logic        lg_last [0:15];
  logic        lg_crc [0:15];
  int n_off, dmst, dcnt;

  // memory model
  always @(posedge clk) begin
    if (rst) begin
      mem_ack  <= 1'b0;
      wait_cnt <= 0;
    end else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        if (wait_cnt >= lat) begin
          mem_ack  <= 1'b1;
          wait_cnt <= 0;
          acc_count = acc_count + 1;
          if (first_seen == 0) begin
            first_seen = 1;
            first_addr = mem_addr;
          end
          if (mem_we) begin
            for (int b = 0; b < 4; b++)
              if (mem_be[b]) mem[mem_addr[7:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
          end else begin
            mem_rdata <= mem[mem_addr[7:2]];
            rd_hist[mem_addr[7:2]] = rd_hist[mem_addr[7:2]] + 1;
            if (int'(mem_addr[7:2]) == arm_idx && arm_left > 0) begin
              arm_left = arm_left - 1;
              if (arm_left == 0) mem[arm_idx][31] <= 1'b1;
            end
          end
        end else begin
          wait_cnt <= wait_cnt + 1;
        end
      end
    end
  end

  // request hold monitor
  logic        prev_pend = 1'b0;
  logic [31:0] prev_addr = '0;
  always @(posedge clk) begin
    if (!rst && prev_pend && mem_req && mem_addr != prev_addr) hold_err = hold_err + 1;
    prev_pend <= mem_req && !mem_ack;
    prev_addr <= mem_addr;
  end

  // data mover model
  always @(posedge clk) begin
    if (rst || !enable) begin
      dm_ready <= 1'b0;
      dm_done  <= 1'b0;
      dmst     <= 0;
      dcnt     <= 0;
    end else begin
      dm_ready <= 1'b0;
      dm_done  <= 1'b0;
      if (dmst == 0) begin
        if (dm_valid && !dm_ready) begin
          if (dcnt >= dly_r) begin
            dm_ready <= 1'b1;
            dcnt     <= 0;
            dmst     <= 1;
            lg_ptr[n_off]  = dm_ptr;
            lg_len[n_off]  = dm_len;
            lg_last[n_off] = dm_last;
            lg_crc[n_off]  = dm_crc;
            n_off = n_off + 1;
          end else dcnt <= dcnt + 1;
        end else dcnt <= 0;
      end else begin
        if (dcnt >= dly_d) begin
          dm_done <= 1'b1;
          dcnt    <= 0;
          dmst    <= 0;
        end else dcnt <= dcnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clr();
    for (int i = 0; i < 64; i++) rd_hist[i] = 0;
    acc_count  = 0;
    first_seen = 0;
    n_off      = 0;
    arm_idx    = -1;
    arm_left   = 0;
  endtask

  function automatic logic [31:0] w0(input bit r, input bit w, input bit l,
                                     input bit c, input int spare, input int len);
    return {r, w, l, c, 12'(spare), 16'(len)};
  endfunction

  task automatic pulse_kick();
    @(negedge clk) kick = 1'b1;
    @(negedge clk) kick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    checks = 0; fails = 0; done_flag = 0; hold_err = 0;
    lat = 0; dly_r = 0; dly_d = 0;
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    clr();
    idle(4);
    @(negedge clk) rst = 1'b0;
    chk(!mem_req && !dm_valid, "R6", "reset idle outputs", {mem_req, dm_valid}, 0);
    // unaligned base value: low bits must be dropped (R10)
    base_wr = 1'b1; base_wdata = 32'h0000_0043;
    @(negedge clk) base_wr = 1'b0;
    idle(2);
    enable = 1'b1;
    idle(2);

    // main sweep over ring length, latencies and flag patterns
    for (int n = 1; n <= 4; n++) begin
      for (int rd = 0; rd < 3; rd++) begin
        lat = rd; dly_r = (n + rd) % 3; dly_d = rd + 1;
        for (int i = 0; i < n; i++) begin
          mem[BASEW + 2*i]     = w0(1'b1, i == n-1, ((i + rd) % 2) == 0, ((i + rd + n) % 2) == 1,
                                    i*3 + n + rd, 16'h100*n + 16*rd + i);
          mem[BASEW + 2*i + 1] = 32'h1000_0000 + (n << 16) + (rd << 8) + i*16;
        end
        mem[BASEW + 2*n]     = w0(1'b1, 1'b0, 1'b1, 1'b1, 12'hfff, 16'hdead);
        mem[BASEW + 2*n + 1] = 32'hbad0_0000;
        clr();
        pulse_kick();
        idle(200);
        chk(first_addr == 32'h40, "R10", "first access aligned at base", first_addr, 32'h40);
        chk(first_seen == 1, "R1", "kick starts fetching", first_seen, 1);
        chk(n_off == n, "R3", "offers in sweep", n_off, n);
        for (int i = 0; i < n && i < n_off; i++) begin
          chk(lg_ptr[i] == 32'h1000_0000 + (n << 16) + (rd << 8) + i*16, "R2", "offered pointer",
              lg_ptr[i], 32'h1000_0000 + (n << 16) + (rd << 8) + i*16);
          chk(lg_len[i] == 16'(16'h100*n + 16*rd + i), "R2", "offered length",
              lg_len[i], 16'(16'h100*n + 16*rd + i));
          chk(lg_last[i] == (((i + rd) % 2) == 0), "R3", "offered last flag",
              lg_last[i], ((i + rd) % 2) == 0);
          chk(lg_crc[i] == (((i + rd + n) % 2) == 1), "R3", "offered crc flag",
              lg_crc[i], ((i + rd + n) % 2) == 1);
          chk(mem[BASEW + 2*i] == w0(1'b0, i == n-1, ((i + rd) % 2) == 0, ((i + rd + n) % 2) == 1,
                                     i*3 + n + rd, 16'h100*n + 16*rd + i),
              "R4", "word0 after write-back", mem[BASEW + 2*i],
              w0(1'b0, i == n-1, ((i + rd) % 2) == 0, ((i + rd + n) % 2) == 1,
                 i*3 + n + rd, 16'h100*n + 16*rd + i));
          chk(mem[BASEW + 2*i + 1] == 32'h1000_0000 + (n << 16) + (rd << 8) + i*16, "R4",
              "pointer word untouched", mem[BASEW + 2*i + 1],
              32'h1000_0000 + (n << 16) + (rd << 8) + i*16);
        end
        chk(rd_hist[BASEW + 2*n] == 0, "R5", "no read past wrap descriptor", rd_hist[BASEW + 2*n], 0);
        chk(rd_hist[BASEW] == 3, "R6", "first descriptor reads incl. double poll", rd_hist[BASEW], 3);
        chk(acc_count == 3*n + 2, "R6", "total accesses then quiet", acc_count, 3*n + 2);
      end
    end

    // R7: flag set between the two polls rescues the descriptor
    lat = 1; dly_r = 1; dly_d = 1;
    mem[BASEW]     = w0(1'b0, 1'b0, 1'b0, 1'b1, 1, 16'h0044);
    mem[BASEW + 1] = 32'h2000_0000;
    mem[BASEW + 2] = w0(1'b1, 1'b1, 1'b1, 1'b0, 2, 16'h0055);
    mem[BASEW + 3] = 32'h2000_0100;
    clr();
    arm_idx = BASEW; arm_left = 1;
    pulse_kick();
    idle(200);
    chk(n_off == 2, "R7", "offers after second-poll rescue", n_off, 2);
    chk(lg_ptr[0] == 32'h2000_0000, "R7", "rescued buffer offered first", lg_ptr[0], 32'h2000_0000);
    chk(acc_count == 9, "R7", "accesses with rescue", acc_count, 9);

    // R8: kick during busy, flag set only after the second poll of d1
    lat = 0; dly_r = 10; dly_d = 2;
    mem[BASEW]     = w0(1'b1, 1'b0, 1'b1, 1'b0, 3, 16'h0066);
    mem[BASEW + 1] = 32'h3000_0000;
    mem[BASEW + 2] = w0(1'b0, 1'b1, 1'b1, 1'b1, 4, 16'h0077);
    mem[BASEW + 3] = 32'h3000_0100;
    clr();
    arm_idx = BASEW + 2; arm_left = 2;
    pulse_kick();
    while (!dm_valid) @(negedge clk);
    pulse_kick();
    idle(250);
    chk(n_off == 2, "R8", "remembered kick picks up late descriptor", n_off, 2);
    chk(n_off == 2 && lg_ptr[1] == 32'h3000_0100, "R8", "second offer pointer", lg_ptr[1], 32'h3000_0100);
    chk(acc_count == 10, "R8", "accesses with replayed kick", acc_count, 10);

    // R9: disable mid-ring
    lat = 0; dly_r = 30; dly_d = 1;
    for (int i = 0; i < 3; i++) begin
      mem[BASEW + 2*i]     = w0(1'b1, i == 2, 1'b0, 1'b0, 5, 16'h10 + i);
      mem[BASEW + 2*i + 1] = 32'h4000_0000 + i*16;
    end
    clr();
    pulse_kick();
    while (!(dm_valid && mem[BASEW][31] == 1'b0)) @(negedge clk);
    enable = 1'b0;
    idle(2);
    chk(!dm_valid && !mem_req, "R9", "outputs idle while disabled", {dm_valid, mem_req}, 0);
    acc_count = 0;
    pulse_kick();
    idle(3);
    enable = 1'b1;
    idle(30);
    chk(acc_count == 0, "R9", "kick while disabled ignored", acc_count, 0);
    chk(mem[BASEW + 2][31] == 1'b1, "R9", "in-flight descriptor not released", mem[BASEW + 2][31], 1);
    clr();
    pulse_kick();
    idle(100);
    chk(first_addr == 32'h40, "R9", "walker restarts at base", first_addr, 32'h40);
    chk(acc_count == 2 && n_off == 0, "R6", "not-ready base polled twice", acc_count, 2);

    chk(hold_err == 0, "R11", "request stable until ack", hold_err, 0);

    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule